// File: doc/BRIEF.md
# Quarter-Table Sine Synthesizer

This block is a direct digital synthesis sine source. A 24-bit phase register is advanced by a frequency control word once every three clock cycles. The ten upper phase bits select one of 1024 points around a full period. Only the first quarter of the waveform is held in a constant table. The other three quarters are rebuilt by reading that table in reverse and by negating the value read.

Each new sample is registered. It appears together with a single-cycle strobe, so a downstream stage can take one sample per strobe. The output frequency is fcw × f_clk / (3 × 2^24). A control word of zero keeps the output at one constant value.

Top module: `qsine_dds`

## Requirements
- R1: The phase register is 24 bits wide and unsigned. On each step it adds the control word and wraps modulo 2^24.
- R2: The phase index is the upper 10 bits of the phase register, bits [23:14]. For index i the output is round(32767 × sin(2πi/1024)), with halves rounded away from zero, as 16-bit two's complement.
- R3: Index bits [9:8] select the quadrant and bits [7:0] give the offset o. The stored table T holds 257 entries, T[k] = round(32767 × sin(πk/512)) for k = 0..256. Quadrant 0 outputs T[o], quadrant 1 outputs T[256−o], quadrant 2 outputs −T[o] and quadrant 3 outputs −T[256−o].
- R4: The output stays within ±32767 and is never −32768. Index 0 gives 0, index 1 gives 201, index 256 gives +32767 and index 768 gives −32767.
- R5: The phase register advances exactly once every three clocks. Once running, the strobe is high for one cycle in every three.
- R6: After reset is released, the first strobe arrives with the fourth rising edge. It carries the sample for phase = fcw. The sample changes only in cycles where the strobe is high.
- R7: An active-high synchronous reset clears the phase register and the cycle divider. While reset is active, the output is 0 and the strobe is low. Asserting reset mid-run restarts the sequence from phase 0.
- R8: With a control word of 0, the strobe keeps its period and every sample after reset is 0.
- R9: The control word is taken at the clock edge that advances the phase. A word changed after a strobe determines the phase carried by the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | 24 | Frequency control word (phase increment) |
| sample | output | 16 | Signed sine sample |
| strobe | output | 1 | High in the cycle a new sample appears |

## Verification
The bench steps the phase index by exactly one point per sample across more than a full period. This catches an off-by-one in the mirrored address: a design that reads entry 255−o instead of 256−o would miss the peaks and put a false plateau at the quadrant seams. A coarse word landing exactly on indices 0, 256, 512 and 768 shows whether the sign is applied to the right quadrants. It also shows whether the peak entry exists at all, since a 256-entry table would give 32766 or wrap to zero there. A word that is not a power of two runs past the 2^24 wrap, and an accumulator that saturated or was narrower would drift off the expected sequence. Other tests check the strobe cadence, the four-edge start-up latency, a change of the control word, and a reset in mid-run; a divider of the wrong modulus or a missing output register would show in these.

// File: rtl/qsine_dds.sv
module qsine_dds #(
  parameter int ACC_W    = 24,
  parameter int IDX_W    = 10,
  parameter int OUT_W    = 16,
  parameter int STEP_DIV = 3,
  parameter int AMPL     = 32767
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ACC_W-1:0]        fcw,
  output logic signed [OUT_W-1:0] sample,
  output logic                    strobe
);
  localparam int  OFF_W = IDX_W - 2;
  localparam int  QLEN  = 1 << OFF_W;
  localparam int  DIV_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam real PI    = 3.14159265358979323846;

  logic [DIV_W-1:0]  div_cnt;
  logic [ACC_W-1:0]  acc;
  logic              pend;
  logic              step;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        quad;
  logic [OFF_W-1:0]  off;
  logic [OFF_W:0]    addr;
  logic [OUT_W-1:0]  mag;
  logic [OUT_W-1:0]  value;
  logic [OUT_W-1:0]  qtab [0:QLEN];

  genvar k;
  generate
    for (k = 0; k <= QLEN; k++) begin : g_tab
      localparam int V = $rtoi(AMPL * $sin(PI / 2.0 * k / QLEN) + 0.5);
      assign qtab[k] = V[OUT_W-1:0];
    end
  endgenerate

  assign step  = (div_cnt == DIV_W'(STEP_DIV - 1));
  assign idx   = acc[ACC_W-1 -: IDX_W];
  assign quad  = idx[IDX_W-1 -: 2];
  assign off   = idx[OFF_W-1:0];
  assign addr  = quad[0] ? ((OFF_W+1)'(QLEN) - {1'b0, off}) : {1'b0, off};
  assign mag   = qtab[addr];
  assign value = quad[1] ? (~mag + 1'b1) : mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      acc     <= '0;
      pend    <= 1'b0;
      sample  <= '0;
      strobe  <= 1'b0;
    end else begin
      div_cnt <= step ? '0 : div_cnt + 1'b1;
      if (step) acc <= acc + fcw;
      pend   <= step;
      strobe <= pend;
      if (pend) sample <= value;
    end
  end
endmodule

// File: rtl/qsine_dds_chk.sv
module qsine_dds_chk #(
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [OUT_W-1:0] sample,
  input logic                    strobe
);
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (sample == '0 && !strobe));

  a_r5_strobe_cadence: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe ##1 !strobe ##1 strobe);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sample != {1'b1, {(OUT_W-1){1'b0}}});

  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !$past(rst)) |-> $stable(sample));
endmodule

bind qsine_dds qsine_dds_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .sample(sample), .strobe(strobe)
);

// File: tb/qsine_dds_test.sv
`timescale 1ns/1ps
module qsine_dds_test;
  localparam real PI = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [23:0]        fcw = '0;
  logic signed [15:0] sample;
  logic               strobe;
  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  qsine_dds uut (.clk(clk), .rst(rst), .fcw(fcw), .sample(sample), .strobe(strobe));

  always #4 clk = ~clk;

  function automatic int exp_val(input int i);
    real r;
    r = 32767.0 * $sin(2.0 * PI * i / 1024.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_strobe(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!strobe && gap < 20);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sample == 0, "R7 sample in reset", int'(sample), 0);
    chk(strobe == 1'b0, "R7 strobe in reset", int'(strobe), 0);
    rst = 1'b0;
  endtask

  task automatic run_sweep(input logic [23:0] f, input int n, input string req);
    logic [23:0] ph;
    int gap;
    fcw = f;
    do_reset();
    ph = '0;
    for (int i = 1; i <= n; i++) begin
      wait_strobe(gap);
      ph = ph + f;
      if (i == 1) chk(gap == 4, "R6 first strobe latency", gap, 4);
      else        chk(gap == 3, "R5 strobe period", gap, 3);
      chk(int'(sample) == exp_val(int'(ph[23:14])), req, int'(sample), exp_val(int'(ph[23:14])));
    end
  endtask

  task automatic test_key_points();
    int gap;
    int expv [4] = '{0, 32767, 0, -32767};
    fcw = 24'h400000;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      wait_strobe(gap);
      chk(int'(sample) == expv[(i + 1) % 4], "R4 quadrant key value", int'(sample), expv[(i + 1) % 4]);
    end
  endtask

  task automatic test_fcw_change();
    int gap;
    logic [23:0] a, b, ph;
    a = 24'h0C8000;
    b = 24'h331000;
    fcw = a;
    do_reset();
    wait_strobe(gap);
    chk(int'(sample) == exp_val(int'(a[23:14])), "R9 before change", int'(sample), exp_val(int'(a[23:14])));
    fcw = b;
    ph = a + b;
    wait_strobe(gap);
    chk(int'(sample) == exp_val(int'(ph[23:14])), "R9 after change", int'(sample), exp_val(int'(ph[23:14])));
    ph = ph + b;
    wait_strobe(gap);
    chk(int'(sample) == exp_val(int'(ph[23:14])), "R9 second step", int'(sample), exp_val(int'(ph[23:14])));
  endtask

  task automatic test_mid_reset();
    int gap;
    logic [23:0] f;
    f = 24'h05A000;
    fcw = f;
    do_reset();
    repeat (5) wait_strobe(gap);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sample == 0, "R7 mid-run reset sample", int'(sample), 0);
    chk(strobe == 1'b0, "R7 mid-run reset strobe", int'(strobe), 0);
    rst = 1'b0;
    wait_strobe(gap);
    chk(gap == 4, "R7 restart latency", gap, 4);
    chk(int'(sample) == exp_val(int'(f[23:14])), "R7 restart phase", int'(sample), exp_val(int'(f[23:14])));
  endtask

  initial begin
    run_sweep(24'h004000, 1030, "R3 one-point sweep");
    test_key_points();
    run_sweep(24'h123457, 60, "R1 wrap sweep");
    run_sweep(24'h000000, 10, "R8 zero word");
    run_sweep(24'h000123, 20, "R2 fine step");
    test_fcw_change();
    test_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule